// File: doc/BRIEF.md
# Guarded Clock Divider Control Register

This block is one 8-bit control register on a simple memory-mapped bus. Its low four bits pick a division ratio for the master clock. The block turns that ratio into a single-cycle clock-enable pulse, which the synchronous logic downstream uses to run at the reduced rate.

A stray write must not be able to slow the system down, so the ratio field is locked. To unlock it, software first writes the unlock pattern: only the top bit is set and every other bit is clear. This opens a window that lasts four clock cycles. During that window, a write carrying a new ratio is accepted and closes the window at once. If no such write arrives, the window closes by itself after four cycles. Writing the unlock pattern again while the window is open does not reset the timer.

A new ratio is applied only when the pulse counter reaches its terminal count. The period that is running when the ratio changes therefore always completes at its old length.

Top module: `clkdiv_guard`

## Requirements
- R1: When `bus_addr` equals `REG_ADDR`, `bus_rdata` shows the window flag at bit 7, zeros at bits 6:4 and the ratio code at bits 3:0. At any other address `bus_rdata` is 0.
- R2: Bits 6:4 always read as zero, and any value written to them has no effect.
- R3: Only a write of exactly 0x80 opens the window. A write with bit 7 high and a nonzero ratio code while the window is closed changes nothing.
- R4: After the opening write, the window flag reads 1 for exactly four clock cycles and then reads 0.
- R5: Writing 0x80 again while the window is open neither clears the flag nor restarts the four-cycle count.
- R6: A write to the ratio code while the window is closed leaves the code unchanged.
- R7: While the window is open, a write with bit 7 low, or a write with bit 7 high and a nonzero code, loads bits 3:0 into the code and closes the window in the same cycle.
- R8: Codes 0 to 8 give one `clk_en` pulse every 2^code cycles. Codes 9 to 15 behave like code 0, giving a pulse every cycle.
- R9: After reset the window is closed, the code is `RST_CODE` (default 0), and `clk_en` pulses every cycle.
- R10: A new code takes effect at the next terminal count. The interval that is running when the code changes still has the old length.
- R11: Writes to any address other than `REG_ADDR` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register address, used for both read and write |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| clk_en | output | 1 | Divided clock-enable pulse |

## Verification
The checker examines every cycle for these properties:
- the reserved bits read zero;
- the window never stays open longer than four cycles;
- the window opens only after an exact unlock write;
- the code changes only while the window is open;
- a qualifying write inside the window loads the code and closes the window;
- the active ratio changes only on a pulse, and the gap between pulses never exceeds the largest ratio.

Some behaviour can only be shown by the bench's scenarios. These include:
- the exact four-cycle length of the window, and the fact that a repeated unlock write does not extend it;
- the measured spacing between pulses for each code, including the reserved codes;
- the full old-length interval that runs across a change of ratio.

// File: rtl/cdg_pkg.sv
package cdg_pkg;
  localparam int CODE_W = 4;
  localparam int REG_W  = 8;
  localparam logic [REG_W-1:0] UNLOCK_PATTERN = 8'h80;

  typedef struct packed {
    logic              win;
    logic [2:0]        rsv;
    logic [CODE_W-1:0] code;
  } ctl_view_t;

  // Code to shift amount; codes above max_shift fall back to 0 (divide by 1).
  function automatic int unsigned code_to_shift(input logic [CODE_W-1:0] code,
                                                input int unsigned max_shift);
    int unsigned c;
    c = 32'(code);
    if (c <= max_shift) return c;
    return 0;
  endfunction

  function automatic ctl_view_t make_view(input logic win, input logic [CODE_W-1:0] code);
    ctl_view_t v;
    v.win  = win;
    v.rsv  = 3'b000;
    v.code = code;
    return v;
  endfunction
endpackage

// File: rtl/cdg_unlock.sv
module cdg_unlock #(
  parameter int WIN_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_req,
  input  logic commit,
  output logic win_open
);
  localparam int WIN_W = (WIN_CYC > 2) ? $clog2(WIN_CYC) : 1;
  localparam logic [WIN_W-1:0] LEFT_INIT = WIN_W'(WIN_CYC - 1);

  logic [WIN_W-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_open <= 1'b0;
      left     <= '0;
    end else if (!win_open) begin
      if (arm_req) begin
        win_open <= 1'b1;
        left     <= LEFT_INIT;
      end
    end else if (commit) begin
      win_open <= 1'b0;
    end else if (left == '0) begin
      win_open <= 1'b0;
    end else begin
      left <= left - 1'b1;
    end
  end
endmodule

// File: rtl/cdg_divsel.sv
module cdg_divsel #(
  parameter int CODE_W   = 4,
  parameter int RST_CODE = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [CODE_W-1:0] new_code,
  output logic [CODE_W-1:0] sel_code
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_code <= CODE_W'(RST_CODE);
    else if (commit) sel_code <= new_code;
  end
endmodule

// File: rtl/cdg_pulse.sv
module cdg_pulse #(
  parameter int CODE_W    = 4,
  parameter int MAX_SHIFT = 8,
  parameter int RST_CODE  = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CODE_W-1:0]    sel_code,
  output logic [MAX_SHIFT-1:0] act_limit,
  output logic                 clk_en
);
  import cdg_pkg::*;
  localparam int CNT_W = MAX_SHIFT;

  function automatic logic [CNT_W-1:0] limit_of(input logic [CODE_W-1:0] code);
    logic [CNT_W:0] one_sh;
    one_sh = (CNT_W+1)'(1) << code_to_shift(code, MAX_SHIFT);
    return CNT_W'(one_sh - 1'b1);
  endfunction

  logic [CNT_W-1:0] cnt;
  logic             terminal;

  assign terminal = (cnt == act_limit);
  assign clk_en   = terminal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      act_limit <= limit_of(CODE_W'(RST_CODE));
    end else if (terminal) begin
      cnt       <= '0;
      act_limit <= limit_of(sel_code);
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/clkdiv_guard.sv
module clkdiv_guard #(
  parameter int          ADDR_W    = 8,
  parameter logic [7:0]  REG_ADDR  = 8'h1C,
  parameter int          WIN_CYC   = 4,
  parameter int          MAX_SHIFT = 8,
  parameter int          RST_CODE  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              clk_en
);
  import cdg_pkg::*;

  logic                 addr_hit;
  logic                 wr_hit;
  logic                 arm_req;
  logic                 commit;
  logic                 win_open;
  logic [CODE_W-1:0]    sel_code;
  logic [MAX_SHIFT-1:0] act_limit;
  logic                 pure_rearm;

  assign addr_hit   = (bus_addr == ADDR_W'(REG_ADDR));
  assign wr_hit     = addr_hit && bus_wr;
  assign arm_req    = wr_hit && (bus_wdata == UNLOCK_PATTERN);
  assign pure_rearm = bus_wdata[7] && (bus_wdata[CODE_W-1:0] == '0);
  assign commit     = wr_hit && win_open && !pure_rearm;

  cdg_unlock #(.WIN_CYC(WIN_CYC)) u_unlock (
    .clk(clk), .rst_n(rst_n), .arm_req(arm_req), .commit(commit), .win_open(win_open)
  );

  cdg_divsel #(.CODE_W(CODE_W), .RST_CODE(RST_CODE)) u_divsel (
    .clk(clk), .rst_n(rst_n), .commit(commit),
    .new_code(bus_wdata[CODE_W-1:0]), .sel_code(sel_code)
  );

  cdg_pulse #(.CODE_W(CODE_W), .MAX_SHIFT(MAX_SHIFT), .RST_CODE(RST_CODE)) u_pulse (
    .clk(clk), .rst_n(rst_n), .sel_code(sel_code), .act_limit(act_limit), .clk_en(clk_en)
  );

  assign bus_rdata = addr_hit ? make_view(win_open, sel_code) : '0;
endmodule

// File: rtl/cdg_checker.sv
module cdg_checker #(
  parameter int         ADDR_W    = 8,
  parameter logic [7:0] REG_ADDR  = 8'h1C,
  parameter int         WIN_CYC   = 4,
  parameter int         MAX_SHIFT = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic                 bus_wr,
  input logic [7:0]           bus_wdata,
  input logic [7:0]           bus_rdata,
  input logic                 clk_en,
  input logic                 win_open,
  input logic [3:0]           sel_code,
  input logic [MAX_SHIFT-1:0] act_limit
);
  logic        hit_w;
  logic [15:0] open_run;
  logic [15:0] gap;
  assign hit_w = bus_wr && (bus_addr == ADDR_W'(REG_ADDR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_run <= '0;
      gap      <= '0;
    end else begin
      open_run <= win_open ? open_run + 1'b1 : '0;
      gap      <= clk_en ? '0 : gap + 1'b1;
    end
  end

  assert_rsv_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[6:4] == 3'b000);
  assert_window_max_R4: assert property (@(posedge clk) disable iff (!rst_n)
    open_run <= 16'(WIN_CYC));
  assert_open_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(win_open) |-> $past(hit_w && bus_wdata == 8'h80));
  assert_code_guard_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sel_code) |-> $past(win_open));
  assert_commit_close_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (win_open && hit_w && bus_wdata[3:0] != 4'h0) |=> (!win_open && sel_code == $past(bus_wdata[3:0])));
  assert_load_at_terminal_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_limit) |-> $past(clk_en));
  assert_gap_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    gap < 16'(1 << MAX_SHIFT));
endmodule

bind clkdiv_guard cdg_checker #(
  .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .WIN_CYC(WIN_CYC), .MAX_SHIFT(MAX_SHIFT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .clk_en(clk_en), .win_open(win_open), .sel_code(sel_code),
  .act_limit(act_limit)
);

// File: tb/clkdiv_guard_tb.sv
`timescale 1ns/1ps
module clkdiv_guard_tb;
  localparam logic [7:0] REG = 8'h1C;
  localparam logic [7:0] OTHER = 8'h1D;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] bus_addr = REG;
  logic bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic clk_en;
  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  int last_pulse = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  clkdiv_guard u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .clk_en(clk_en)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ratio_of(input int code);
    return (code <= 8) ? (1 << code) : 1;
  endfunction

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0; bus_wdata = 8'h00; bus_addr = REG;
  endtask

  task automatic bus_read(input logic [7:0] a, output int v);
    bus_addr = a; #0.5; v = int'(bus_rdata); bus_addr = REG;
  endtask

  task automatic next_interval(output int iv);
    int guard = 0;
    do begin @(negedge clk); guard++; end while (!clk_en && guard < 600);
    iv = cyc - last_pulse;
    last_pulse = cyc;
  endtask

  task automatic set_code(input logic [7:0] d);
    bus_write(REG, 8'h80);
    bus_write(REG, d);
  endtask

  task automatic measure(input int code, input string req);
    int iv;
    next_interval(iv); next_interval(iv); next_interval(iv);
    check(req, iv, ratio_of(code));
  endtask

  task automatic t_reset;
    int v;
    bus_read(REG, v); check("R9 reset view", v, 0);
    measure(0, "R9 reset ratio");
  endtask

  task automatic t_window_len;
    int v;
    bus_write(REG, 8'h80);
    for (int k = 0; k < 4; k++) begin
      bus_read(REG, v); check("R4 window open", (v >> 7) & 1, 1);
      @(negedge clk);
    end
    bus_read(REG, v); check("R4 window closed", v, 0);
  endtask

  task automatic t_rearm;
    int v;
    bus_write(REG, 8'h80);
    bus_write(REG, 8'h80);
    bus_read(REG, v); check("R5 still open", (v >> 7) & 1, 1);
    @(negedge clk);
    bus_read(REG, v); check("R5 still open 2", (v >> 7) & 1, 1);
    @(negedge clk);
    bus_read(REG, v); check("R5 not extended", (v >> 7) & 1, 0);
  endtask

  task automatic t_arm_bad;
    int v;
    bus_write(REG, 8'h81);
    bus_read(REG, v); check("R3 arm with code ignored", v, 0);
    bus_write(REG, 8'h90);
    bus_read(REG, v); check("R3 arm with reserved bit ignored", v, 0);
  endtask

  task automatic t_outside;
    int v;
    bus_write(REG, 8'h03);
    bus_read(REG, v); check("R6 closed write", v, 0);
    bus_write(REG, 8'h80);
    repeat (4) @(negedge clk);
    bus_write(REG, 8'h02);
    bus_read(REG, v); check("R6 expired write", v, 0);
  endtask

  task automatic t_other_addr;
    int v;
    bus_write(OTHER, 8'h80);
    bus_write(OTHER, 8'h05);
    bus_read(REG, v); check("R11 other address", v, 0);
    bus_read(OTHER, v); check("R1 other address reads 0", v, 0);
  endtask

  task automatic t_commit;
    int v;
    set_code(8'h72);
    bus_read(REG, v); check("R7 R2 commit low bit7", v, 2);
    measure(2, "R8 code 2");
    bus_write(REG, 8'h80);
    bus_write(REG, 8'h85);
    bus_read(REG, v); check("R7 R1 commit high bit7", v, 5);
    measure(5, "R8 code 5");
  endtask

  task automatic t_ratios;
    int v;
    set_code(8'h08); measure(8, "R8 code 8");
    set_code(8'h09);
    bus_read(REG, v); check("R1 reserved code stored", v, 9);
    measure(9, "R8 code 9");
    set_code(8'h0F); measure(15, "R8 code 15");
  endtask

  task automatic t_switch;
    int iv;
    set_code(8'h03);
    measure(3, "R10 settle 8");
    next_interval(iv);
    set_code(8'h01);
    next_interval(iv); check("R10 old interval kept", iv, 8);
    next_interval(iv); check("R10 new interval", iv, 2);
  endtask

  initial begin
    #(5.0 * 150000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_window_len();
    t_rearm();
    t_arm_bad();
    t_outside();
    t_other_addr();
    t_commit();
    t_ratios();
    t_switch();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule